// File: doc/BRIEF.md
# PLL Control and Lock Status Register

This block is the control and status word for a single PLL. Software writes one 32-bit word that carries the four divider settings and a power-down request. The register takes those fields as written. It keeps two status bits that the write rules set, not the write data. The first is a live lock indicator. The second is a sticky loss-of-lock flag that software clears by writing 1 to it. The PLL itself is outside the block. Lock is modelled as immediate: any write that leaves the PLL running is taken as locked in the same update.

The divider fields and the status bits go straight to the clock tree. A one-cycle frequency-update strobe tells downstream clock logic to recompute after each write that leaves the PLL locked. For test, a ratio port gives the output-to-reference ratio as a numerator (the feedback divider) and a denominator (input divider times both output dividers). The ratio port reads zero when the PLL is unlocked or when any divider is zero.

Top module: `pll_ctl_reg`

## Requirements
- R1: After reset the word reads 0x80222101. That is locked (bit 31) = 1, loss flag (bit 30) = 0, feedback divider 34, both output dividers 1, input divider 1, power-down 0.
- R2: A write with bit 12 (power-down) set clears the lock bit and sets the loss flag, whatever bit 30 of the write data holds.
- R3: A write with bit 12 clear sets the lock bit. The value written to bit 31 has no effect on it.
- R4: On a write with bit 12 clear, a 1 in bit 30 clears the loss flag and a 0 leaves it unchanged.
- R5: Bits 29:28, 11 and 7:6 always read 0.
- R6: The divider fields are stored as written and appear both in the word and on their own ports. The fields are feedback in bits 27:16, second output divider in bits 15:13, first output divider in bits 10:8 and input divider in bits 5:0.
- R7: The update strobe is high for exactly the one cycle after a write that leaves the lock bit set. It stays low after power-down writes and in cycles with no write.
- R8: With test mode on, the PLL locked and all four dividers nonzero, the ratio numerator equals the feedback divider. The denominator equals the input divider times the first output divider times the second output divider.
- R9: While the lock bit is clear, both ratio outputs are 0.
- R10: If any divider field is 0, both ratio outputs are 0.
- R11: With test mode off, both ratio outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the word |
| wr_data_i | input | 32 | Write data |
| test_en_i | input | 1 | Enables the ratio outputs |
| rd_data_o | output | 32 | Current register word |
| fb_div_o | output | 12 | Feedback divider |
| out_div2_o | output | 3 | Second output divider |
| out_div1_o | output | 3 | First output divider |
| in_div_o | output | 6 | Input divider |
| pdown_o | output | 1 | Power-down request |
| locked_o | output | 1 | Live lock indicator |
| lock_lost_o | output | 1 | Sticky loss-of-lock flag |
| freq_upd_o | output | 1 | One-cycle frequency-update strobe |
| ratio_num_o | output | 12 | Test ratio numerator |
| ratio_den_o | output | 12 | Test ratio denominator |

## Verification
The block has no hidden state beyond the word itself, so a wrong status or field bit shows on rd_data_o in the first cycle after the write that caused it. A wrong ratio is visible on the same cycle, and a missing or spurious strobe on the cycle after the write. The bench therefore checks every port at the negative edge right after each write. It sweeps every combination of input and output dividers, so a slip in field position, the zero-divider rule or the product shows up within that sweep. Separate write sequences drive the loss flag through set, hold and clear. These catch a flag that clears on a 0 or forgets its state across a running write.

// File: rtl/pll_reg_pkg.sv
package pll_reg_pkg;
  localparam int WORD_W   = 32;
  localparam int LOCK_BIT = 31;
  localparam int LOSS_BIT = 30;
  localparam int FB_LSB   = 16;
  localparam int FB_W     = 12;
  localparam int OD2_LSB  = 13;
  localparam int PD_BIT   = 12;
  localparam int OD1_LSB  = 8;
  localparam int OD_W     = 3;
  localparam int IN_LSB   = 0;
  localparam int IN_W     = 6;
  localparam int DEN_W    = IN_W + 2 * OD_W;

  typedef struct packed {
    logic [FB_W-1:0] fb;
    logic [OD_W-1:0] od2;
    logic            pd;
    logic [OD_W-1:0] od1;
    logic [IN_W-1:0] ind;
  } pll_cfg_t;

  function automatic pll_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
    pll_cfg_t c;
    c.fb  = w[FB_LSB  +: FB_W];
    c.od2 = w[OD2_LSB +: OD_W];
    c.pd  = w[PD_BIT];
    c.od1 = w[OD1_LSB +: OD_W];
    c.ind = w[IN_LSB  +: IN_W];
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] word_from_cfg(input pll_cfg_t c,
                                                      input logic lock,
                                                      input logic loss);
    logic [WORD_W-1:0] w;
    w = '0;
    w[LOCK_BIT]            = lock;
    w[LOSS_BIT]            = loss;
    w[FB_LSB  +: FB_W]     = c.fb;
    w[OD2_LSB +: OD_W]     = c.od2;
    w[PD_BIT]              = c.pd;
    w[OD1_LSB +: OD_W]     = c.od1;
    w[IN_LSB  +: IN_W]     = c.ind;
    return w;
  endfunction
endpackage

// File: rtl/pll_cfg_store.sv
module pll_cfg_store
  import pll_reg_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WORD = 32'h8022_2101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output pll_cfg_t          cfg_o,
  output logic              lock_o,
  output logic              loss_o,
  output logic              upd_o
);
  localparam pll_cfg_t RST_CFG = cfg_from_word(RST_WORD);

  pll_cfg_t wr_cfg;
  pll_cfg_t cfg_q;
  logic     lock_q, loss_q, upd_q;

  assign wr_cfg = cfg_from_word(wr_data_i);

  // status bits follow the write rules, not the data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= RST_CFG;
      lock_q <= RST_WORD[LOCK_BIT];
      loss_q <= RST_WORD[LOSS_BIT];
      upd_q  <= 1'b0;
    end else if (wr_en_i) begin
      cfg_q <= wr_cfg;
      if (wr_cfg.pd) begin
        lock_q <= 1'b0;
        loss_q <= 1'b1;
        upd_q  <= 1'b0;
      end else begin
        lock_q <= 1'b1;
        loss_q <= loss_q & ~wr_data_i[LOSS_BIT];
        upd_q  <= 1'b1;
      end
    end else begin
      upd_q <= 1'b0;
    end
  end

  assign cfg_o  = cfg_q;
  assign lock_o = lock_q;
  assign loss_o = loss_q;
  assign upd_o  = upd_q;

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data_i[LOCK_BIT], wr_data_i[29:28],
                            wr_data_i[11], wr_data_i[7:6]};

  // R2
  pd_drops_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_data_i[PD_BIT] |=> !lock_q && loss_q);
  // R3
  run_sets_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[PD_BIT] |=> lock_q);
  // R4
  loss_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[PD_BIT] && !wr_data_i[LOSS_BIT] |=> loss_q == $past(loss_q));
  // R4
  loss_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !wr_data_i[PD_BIT] && wr_data_i[LOSS_BIT] |=> !loss_q);
  // R7
  upd_needs_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_q |-> lock_q);
  // R7
  idle_no_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !upd_q);
  // R6
  idle_cfg_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_q) && $stable(lock_q));
endmodule

// File: rtl/pll_ratio_calc.sv
module pll_ratio_calc
  import pll_reg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  pll_cfg_t         cfg_i,
  input  logic             lock_i,
  input  logic             test_en_i,
  output logic [FB_W-1:0]  num_o,
  output logic [DEN_W-1:0] den_o
);
  logic             zero_fld;
  logic             valid;
  logic [DEN_W-1:0] prod;

  // any zero divider is a config error: report zero, never divide by it
  assign zero_fld = (cfg_i.fb == '0) || (cfg_i.od1 == '0) ||
                    (cfg_i.od2 == '0) || (cfg_i.ind == '0);
  assign valid    = test_en_i && lock_i && !zero_fld;
  assign prod     = DEN_W'(cfg_i.ind) * DEN_W'(cfg_i.od1) * DEN_W'(cfg_i.od2);
  assign num_o    = valid ? cfg_i.fb : '0;
  assign den_o    = valid ? prod : '0;

  // R9
  unlocked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |-> num_o == '0 && den_o == '0);
  // R10
  nonzero_den_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    den_o != '0 |-> num_o != '0 && cfg_i.ind != '0);
  // R11
  test_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_en_i |-> num_o == '0 && den_o == '0);
endmodule

// File: rtl/pll_ctl_reg.sv
module pll_ctl_reg
  import pll_reg_pkg::*;
#(
  parameter logic [WORD_W-1:0] RST_WORD = 32'h8022_2101
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              test_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [FB_W-1:0]   fb_div_o,
  output logic [OD_W-1:0]   out_div2_o,
  output logic [OD_W-1:0]   out_div1_o,
  output logic [IN_W-1:0]   in_div_o,
  output logic              pdown_o,
  output logic              locked_o,
  output logic              lock_lost_o,
  output logic              freq_upd_o,
  output logic [FB_W-1:0]   ratio_num_o,
  output logic [DEN_W-1:0]  ratio_den_o
);
  pll_cfg_t cfg;
  logic     lock, loss, upd;

  pll_cfg_store #(.RST_WORD(RST_WORD)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .cfg_o     (cfg),
    .lock_o    (lock),
    .loss_o    (loss),
    .upd_o     (upd)
  );

  pll_ratio_calc u_ratio (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_i     (cfg),
    .lock_i    (lock),
    .test_en_i (test_en_i),
    .num_o     (ratio_num_o),
    .den_o     (ratio_den_o)
  );

  assign rd_data_o   = word_from_cfg(cfg, lock, loss);
  assign fb_div_o    = cfg.fb;
  assign out_div2_o  = cfg.od2;
  assign out_div1_o  = cfg.od1;
  assign in_div_o    = cfg.ind;
  assign pdown_o     = cfg.pd;
  assign locked_o    = lock;
  assign lock_lost_o = loss;
  assign freq_upd_o  = upd;

  // R5
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[29:28] == 2'b00 && !rd_data_o[11] && rd_data_o[7:6] == 2'b00);
  // R2
  pd_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdown_o |-> !locked_o && lock_lost_o);
endmodule

// File: tb/tb_pll_ctl_reg.sv
module tb_pll_ctl_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        test_en_i = 1'b0;
  logic [31:0] rd_data_o;
  logic [11:0] fb_div_o;
  logic [2:0]  out_div2_o, out_div1_o;
  logic [5:0]  in_div_o;
  logic        pdown_o, locked_o, lock_lost_o, freq_upd_o;
  logic [11:0] ratio_num_o, ratio_den_o;

  int n_vec = 0;
  int n_bad = 0;
  logic exp_lock = 1'b1;
  logic exp_loss = 1'b0;

  always #4 clk_i = ~clk_i;

  pll_ctl_reg dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [31:0] d, input logic lk, input logic ls);
    return {lk, ls, 2'b00, d[27:16], d[15:13], d[12], 1'b0, d[10:8], 2'b00, d[5:0]};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wr_data_i = d;
    if (d[12]) begin
      exp_lock = 1'b0; exp_loss = 1'b1;
    end else begin
      exp_lock = 1'b1; exp_loss = exp_loss & ~d[30];
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic chk_ratio(input string req, input logic [31:0] d);
    logic ok;
    logic [11:0] en, ed;
    ok = test_en_i && exp_lock && d[27:16] != 0 && d[15:13] != 0 && d[10:8] != 0 && d[5:0] != 0;
    en = ok ? d[27:16] : 12'd0;
    ed = ok ? 12'(d[5:0] * d[10:8] * d[15:13]) : 12'd0;
    chk({req, " num"}, 32'(ratio_num_o), 32'(en));
    chk({req, " den"}, 32'(ratio_den_o), 32'(ed));
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    test_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 word", rd_data_o, 32'h8022_2101);
    chk("R1 lock", 32'(locked_o), 1);
    chk("R1 loss", 32'(lock_lost_o), 0);
    chk("R6 fb", 32'(fb_div_o), 34);
    chk_ratio("R8 reset", 32'h8022_2101);
    // R7 idle cycles give no strobe
    repeat (3) begin
      @(negedge clk_i);
      chk("R7 idle", 32'(freq_upd_o), 0);
    end
    // R2 power-down
    d = 32'h0045_3A05;
    wr(d);
    chk("R2 word", rd_data_o, exp_word(d, 1'b0, 1'b1));
    chk("R7 pd no strobe", 32'(freq_upd_o), 0);
    chk_ratio("R9 unlocked", d);
    chk("R9 num", 32'(ratio_num_o), 0);
    // R3/R4 run with loss bit 0: loss held
    d = 32'h8045_2A05;
    wr(d);
    chk("R3 lock", 32'(locked_o), 1);
    chk("R4 hold", 32'(lock_lost_o), 1);
    chk("R7 strobe", 32'(freq_upd_o), 1);
    chk_ratio("R8 after run", d);
    @(negedge clk_i);
    chk("R7 one cycle", 32'(freq_upd_o), 0);
    // R4 clear by 1
    d = 32'h4045_2A05;
    wr(d);
    chk("R4 clear", 32'(lock_lost_o), 0);
    chk("R3 bit31 ignored", 32'(locked_o), 1);
    d = 32'h4011_2101;
    wr(d);
    chk("R4 stays clear", 32'(lock_lost_o), 0);
    // R2 bit30 set with power-down still sets loss
    d = 32'h4011_3101;
    wr(d);
    chk("R2 loss set", 32'(lock_lost_o), 1);
    chk("R2 lock clr", 32'(locked_o), 0);
    // R5 reserved bits
    d = 32'h7FFF_EFFF;
    wr(d);
    chk("R5 word", rd_data_o, exp_word(d, 1'b1, 1'b0));
    chk("R5 rsvd", rd_data_o & 32'h3000_08C0, 0);
    // sweep all input/output divider combinations
    for (int ind = 0; ind < 64; ind++) begin
      for (int o1 = 0; o1 < 8; o1++) begin
        for (int o2 = 0; o2 < 8; o2++) begin
          logic [11:0] fb;
          fb = 12'((ind * 37 + o1 * 5 + o2 * 3) % 4096);
          test_en_i = (o1 != 3);
          d = {4'b0000, fb, 3'(o2), 1'b0, 1'b0, 3'(o1), 2'b00, 6'(ind)};
          wr(d);
          chk("R6 word", rd_data_o, exp_word(d, 1'b1, exp_loss));
          chk("R6 fields", {fb_div_o, out_div2_o, out_div1_o, in_div_o, pdown_o, 2'b00},
              {fb, 3'(o2), 3'(o1), 6'(ind), 1'b0, 2'b00});
          chk_ratio(o1 == 3 ? "R11 test off" : "R10 R8 sweep", d);
          chk("R7 sweep strobe", 32'(freq_upd_o), 1);
        end
      end
    end
    test_en_i = 1'b1;
    @(negedge clk_i);
    chk("R7 end", 32'(freq_upd_o), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule